// File: doc/BRIEF.md
# Glitch-Free Clock Output Bank Disable

This block sits between a running source clock and one bank of clock output pads. It takes a per-bank disable request and a decoded three-level mode select, and from them produces the clock that leaves the bank and an output-enable for the pad drivers. The bank can be in one of three states:

- **Enabled:** the bank passes the clock through.
- **Stop-low:** the clock is stopped at logic low without any shortened pulse.
- **Floating:** the output enable is dropped so the pads go to high impedance.

A mid (test) mode makes the bank ignore its disable request.

The stop-low path is timed by the clock. The disable request is synchronized on the falling edge of the source clock. A gate that only changes while the source clock is low then stops or restarts the clock, so every high pulse that leaves the bank is full width. The floating path is purely combinational and acts at once, without waiting for any clock edge. Reset is synchronous and active high, and it is sampled on the same falling edge that drives the synchronizer.

Top module: `bank_out_gate`

## Requirements
- R1: While `rst` is high at a falling edge of `clk_src`, the synchronizer is cleared. After reset the bank is enabled: `clk_out` follows `clk_src` and `oe` is 1 when `dis_req` is 0.
- R2: `mode_sel` encoding: 2'b00 = low (float on disable), 2'b01 = mid (test), 2'b10 = high (stop-low on disable), 2'b11 = treated as mid. With `dis_req` at 0, `oe` is 1 and `clk_out` follows `clk_src` in every mode.
- R3: With `mode_sel` = 2'b10 and `dis_req` = 1, `clk_out` is held at 0 and `oe` stays 1.
- R4: `clk_out` is never high while `clk_src` is low, and every high pulse of `clk_out` lasts the full high time of `clk_src`.
- R5: A stop-low request is taken on the SYNC_STAGES-th falling edge of `clk_src` after it appears. With the default of 2 stages, exactly one further full pulse leaves the bank. The stop always completes within 6 source clock cycles.
- R6: When the stop-low request is removed, the gate reopens on a falling edge after the same synchronizer latency. The first pulse out is full width, and the clock runs again within 6 cycles.
- R7: With `mode_sel` = 2'b00 and `dis_req` = 1, `oe` is 0 at once, combinationally, with no clock edge needed. `clk_out` keeps running behind the disabled driver.
- R8: In test mode (`mode_sel` 2'b01 or 2'b11), `dis_req` has no effect: `oe` is 1 and the clock is not stopped. A stop that was in force releases through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Running source clock to be passed to the bank |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge of `clk_src` |
| dis_req | input | 1 | Bank disable request |
| mode_sel | input | 2 | Decoded output mode: 00 low, 01 mid, 10 high, 11 mid |
| clk_out | output | 1 | Gated clock for the bank |
| oe | output | 1 | Output enable for the bank's pad drivers; 0 means high impedance |

## Verification
The bound checker watches the following on every cycle:
- `clk_out` is never high while the source is low.
- The enable levels that each mode demands are present.
- A held stop-low request has silenced the clock within six cycles.
- A removed request has let the clock run again within six cycles.

Only the bench scenarios can show the rest:
- The exact one-pulse latency of the stop.
- Pulse widths measured in time around short and back-to-back disable requests.
- The instant drop of `oe` between clock edges.
- Release of a stop when the mode moves into test.

// File: rtl/obd_pkg.sv
package obd_pkg;

    typedef enum logic [1:0] {
        BM_LOW      = 2'b00,
        BM_TEST     = 2'b01,
        BM_HIGH     = 2'b10,
        BM_TEST_ALT = 2'b11
    } bank_mode_e;

    typedef struct packed {
        logic stop_req;
        logic drive_en;
    } bank_ctrl_t;

    localparam int MAX_STOP_CYCLES = 6;

    function automatic logic mode_is_test(input bank_mode_e m);
        return (m == BM_TEST) || (m == BM_TEST_ALT);
    endfunction

    function automatic bank_ctrl_t decode_ctrl(input bank_mode_e m, input logic dis);
        bank_ctrl_t c;
        c.stop_req = dis && (m == BM_HIGH);
        c.drive_en = !(dis && (m == BM_LOW));
        return c;
    endfunction

endpackage

// File: rtl/obd_mode_decode.sv
module obd_mode_decode
    import obd_pkg::*;
(
    input  logic       dis_req,
    input  logic [1:0] mode_raw,
    output bank_ctrl_t ctrl
);
    bank_mode_e mode;

    always_comb begin
        mode = bank_mode_e'(mode_raw);
        ctrl = decode_ctrl(mode, dis_req);
    end
endmodule

// File: rtl/obd_fall_sync.sv
module obd_fall_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic stg;
            always_ff @(negedge clk) begin
                if (rst) stg <= 1'b0;
                else     stg <= d;
            end
            assign q = stg;
        end else begin : g_chain
            logic [STAGES-1:0] stg;
            always_ff @(negedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[STAGES-2:0], d};
            end
            assign q = stg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/obd_clk_gate.sv
module obd_clk_gate (
    input  logic clk_src,
    input  logic stop,
    output logic clk_gated
);
    // stop only changes on a falling edge, so the AND cannot chop a high phase
    assign clk_gated = clk_src & ~stop;
endmodule

// File: rtl/bank_out_gate.sv
module bank_out_gate
    import obd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_src,
    input  logic       rst,
    input  logic       dis_req,
    input  logic [1:0] mode_sel,
    output logic       clk_out,
    output logic       oe
);
    bank_ctrl_t ctrl;
    logic       stop_q;

    obd_mode_decode u_decode (
        .dis_req  (dis_req),
        .mode_raw (mode_sel),
        .ctrl     (ctrl)
    );

    obd_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk_src),
        .rst (rst),
        .d   (ctrl.stop_req),
        .q   (stop_q)
    );

    obd_clk_gate u_gate (
        .clk_src   (clk_src),
        .stop      (stop_q),
        .clk_gated (clk_out)
    );

    assign oe = ctrl.drive_en;
endmodule

// File: rtl/bank_out_gate_chk.sv
module bank_out_gate_chk
    import obd_pkg::*;
(
    input logic       clk_src,
    input logic       rst,
    input logic       dis_req,
    input logic [1:0] mode_sel,
    input logic       clk_out,
    input logic       oe
);
    logic       hold_want;
    logic [3:0] hold_cnt;
    logic [3:0] run_cnt;

    assign hold_want = dis_req && (mode_sel == 2'b10);

    always_ff @(negedge clk_src) begin
        if (rst) begin
            hold_cnt <= '0;
            run_cnt  <= '0;
        end else begin
            hold_cnt <= hold_want ? ((hold_cnt == 4'hF) ? hold_cnt : hold_cnt + 4'd1) : 4'd0;
            run_cnt  <= !hold_want ? ((run_cnt == 4'hF) ? run_cnt : run_cnt + 4'd1) : 4'd0;
        end
    end

    // R4
    no_high_while_src_low_chk: assert property (@(posedge clk_src) disable iff (rst)
        !clk_out);

    // R5
    stop_bound_chk: assert property (@(negedge clk_src) disable iff (rst)
        (hold_cnt >= 4'(MAX_STOP_CYCLES)) |-> !clk_out);

    // R6
    restart_bound_chk: assert property (@(negedge clk_src) disable iff (rst)
        (run_cnt >= 4'(MAX_STOP_CYCLES)) |-> clk_out);

    // R7
    float_drop_chk: assert property (@(posedge clk_src) disable iff (rst)
        (mode_sel == 2'b00 && dis_req) |-> !oe);

    // R3
    hold_keeps_drive_chk: assert property (@(posedge clk_src) disable iff (rst)
        (mode_sel == 2'b10) |-> oe);

    // R8
    test_mode_drive_chk: assert property (@(posedge clk_src) disable iff (rst)
        (mode_sel[0] == 1'b1) |-> oe);
endmodule

bind bank_out_gate bank_out_gate_chk u_chk (
    .clk_src  (clk_src),
    .rst      (rst),
    .dis_req  (dis_req),
    .mode_sel (mode_sel),
    .clk_out  (clk_out),
    .oe       (oe)
);

// File: tb/tb_bank_out_gate.sv
`timescale 1ns/1ps
module tb_bank_out_gate;
    localparam int  STG    = 2;
    localparam real HALF   = 2.5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dis = 1'b0;
    logic [1:0] mode = 2'b10;
    logic       clk_out, oe;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    running = 0;
    bit    done = 0;
    bit    hist[$];
    bit    model_stop = 0;
    real   t_rise = 0.0;

    always #(HALF) clk = ~clk;

    bank_out_gate #(.SYNC_STAGES(STG)) dut (
        .clk_src (clk), .rst (rst), .dis_req (dis),
        .mode_sel (mode), .clk_out (clk_out), .oe (oe)
    );

    function automatic bit want_stop(logic [1:0] m, logic d);
        return d && (m == 2'b10);
    endfunction

    function automatic bit want_oe(logic [1:0] m, logic d);
        return !(d && (m == 2'b00));
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural model: request history of the last STG falling edges
    always @(negedge clk) begin
        if (rst) begin
            hist.delete();
            for (int i = 0; i < STG; i++) hist.push_back(1'b0);
        end else begin
            hist.push_back(want_stop(mode, dis));
            while (hist.size() > STG) void'(hist.pop_front());
        end
        model_stop = (hist.size() == STG) ? hist[0] : 1'b0;
    end

    always @(posedge clk) begin
        #1;
        if (running) begin
            check(cur_req, "clk_out high phase", clk_out, !model_stop);
            check(cur_req, "oe", oe, want_oe(mode, dis));
        end
    end

    always @(negedge clk) begin
        #1;
        if (running) check("R4", "clk_out low phase", clk_out, 1'b0);
    end

    // pulse width monitor
    always @(posedge clk_out) t_rise = $realtime;
    always @(negedge clk_out) begin
        if (running && !done) begin
            n_cmp++;
            if ($realtime - t_rise < HALF - 0.01) begin
                n_bad++;
                $display("FAIL R4/R6 pulse width: actual=%0.3f expected>=%0.3f at %0t",
                         $realtime - t_rise, HALF, $time);
            end
        end
    end

    task automatic drive(input logic d, input logic [1:0] m);
        @(posedge clk);
        #2;
        dis  = d;
        mode = m;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(1_000_000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int  cnt;
        bit  seen_low;
        // R1: reset with a stop request present
        dis = 1'b1; mode = 2'b10;
        wait_cycles(4);
        @(posedge clk); #1;
        check("R1", "clk_out during reset", clk_out, 1'b1);
        drive(1'b0, 2'b10);
        rst = 1'b0;
        running = 1;
        cur_req = "R1";
        wait_cycles(3);

        // R2: enabled in every mode
        cur_req = "R2";
        drive(1'b0, 2'b00); wait_cycles(3);
        drive(1'b0, 2'b01); wait_cycles(3);
        drive(1'b0, 2'b11); wait_cycles(3);
        drive(1'b0, 2'b10); wait_cycles(3);

        // R5: one more pulse, then stopped; bound of 6
        cur_req = "R5";
        drive(1'b1, 2'b10);
        cnt = 0; seen_low = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #1;
            cnt++;
            if (!seen_low && !clk_out) begin
                seen_low = 1;
                check("R5", "stop cycle index", (cnt == STG), 1'b1);
                check("R5", "stop within 6", (cnt <= 6), 1'b1);
            end
        end
        check("R5", "stop seen", seen_low, 1'b1);

        // R3: held low, oe still driving
        cur_req = "R3";
        wait_cycles(4);
        @(posedge clk); #1;
        check("R3", "clk_out held", clk_out, 1'b0);
        check("R3", "oe held", oe, 1'b1);

        // R6: release, first pulse full width (pulse monitor)
        cur_req = "R6";
        drive(1'b0, 2'b10);
        cnt = 0; seen_low = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #1;
            cnt++;
            if (!seen_low && clk_out) begin
                seen_low = 1;
                check("R6", "restart within 6", (cnt <= 6), 1'b1);
            end
        end
        check("R6", "restart seen", seen_low, 1'b1);

        // R4: short and back-to-back requests
        cur_req = "R4";
        drive(1'b1, 2'b10); drive(1'b0, 2'b10);
        drive(1'b1, 2'b10); drive(1'b1, 2'b10); drive(1'b0, 2'b10);
        drive(1'b1, 2'b10); drive(1'b0, 2'b10); drive(1'b1, 2'b10);
        wait_cycles(4);
        drive(1'b0, 2'b10);
        wait_cycles(4);

        // R7: immediate float in low mode, clock still running
        cur_req = "R7";
        @(posedge clk); #2;
        dis = 1'b1; mode = 2'b00;
        #0.1;
        check("R7", "oe immediate", oe, 1'b0);
        wait_cycles(4);
        @(posedge clk); #1;
        check("R7", "clk_out runs behind float", clk_out, 1'b1);
        @(posedge clk); #2;
        dis = 1'b0;
        #0.1;
        check("R7", "oe immediate restore", oe, 1'b1);
        wait_cycles(2);

        // R8: test modes ignore disable; stop releases on entry to test
        cur_req = "R8";
        drive(1'b1, 2'b01); wait_cycles(4);
        @(posedge clk); #1;
        check("R8", "clk_out runs in test", clk_out, 1'b1);
        drive(1'b1, 2'b11); wait_cycles(4);
        drive(1'b1, 2'b10); wait_cycles(5);
        @(posedge clk); #1;
        check("R8", "stopped before test entry", clk_out, 1'b0);
        drive(1'b1, 2'b01); wait_cycles(5);
        @(posedge clk); #1;
        check("R8", "stop released in test", clk_out, 1'b1);
        check("R8", "oe in test", oe, 1'b1);

        // R1: reset re-entry clears a held stop
        cur_req = "R1";
        drive(1'b1, 2'b10); wait_cycles(5);
        running = 0;
        @(posedge clk); #2; rst = 1'b1;
        wait_cycles(2);
        @(posedge clk); #1;
        check("R1", "reset clears stop", clk_out, 1'b1);
        @(posedge clk); #2; rst = 1'b0; dis = 1'b0;
        running = 1;
        wait_cycles(4);

        done = 1;
        running = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule